// File: doc/BRIEF.md
# Synchronous Direct-Update Gray Counter

This block is a free-running counter whose register always holds a reflected-binary Gray value. No binary count is kept and nothing is converted. Each flip-flop has its own toggle rule, worked out from the present state and fed back to its D input.

When the whole state has even parity, bit 0 flips. When the parity is odd, the bit just above the lowest set bit flips. The single exception is the state with only the top bit set. From that state the top bit itself flips, so the count wraps to zero.

A synchronous reset clears the register. A count enable steps it once per clock edge. The width is a parameter: the default is 3, and 2 is the smallest width allowed.

Top module: `gray_step_counter`

## Requirements
- R1: A clock edge with `rst` high loads all zeros into `grayOut`.
- R2: `rst` wins over `countEn`: with both high, `grayOut` is zero after the edge.
- R3: With `rst` low and `countEn` low, `grayOut` keeps its value across the edge.
- R4: Every enabled edge changes exactly one bit of `grayOut`.
- R5: At the default width of 3, enabled steps from reset give 000, 001, 011, 010, 110, 111, 101, 100 and then 000 again.
- R6: After k enabled steps from reset, `grayOut` equals b XOR (b >> 1), where b = k mod 2^WIDTH. This holds at widths 2, 3 and 5.
- R7: From the state with only the top bit set, an enabled edge returns `grayOut` to zero.
- R8: From an even-parity state, an enabled edge flips only bit 0. From an odd-parity state it flips one bit other than bit 0.
- R9: At width 2, the enabled sequence is 00, 01, 11, 10 and then 00 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| countEn | input | 1 | Advances the count by one Gray step on the edge when high |
| grayOut | output | WIDTH | Current Gray-coded count |

## Verification
On every cycle, the assertions check four things:
- An enabled step changes a single bit.
- Bit 0 alone moves from an even-parity state.
- The all-zero state follows a reset and also follows the top-bit-only state.
- Idle cycles leave the state unchanged.

Three things can only be shown by the bench scenarios:
- The exact order of the codes.
- Agreement with a converted reference binary count over more than one full period, at several widths.
- Reset winning over an active enable.

// File: rtl/gray_pkg.sv
package gray_pkg;
  typedef struct packed {
    logic clear;
    logic advance;
  } ctrl_strobe_t;
endpackage

// File: rtl/gray_ctrl.sv
module gray_ctrl
  import gray_pkg::*;
(
  input  logic         rst,
  input  logic         countEn,
  output ctrl_strobe_t strobe
);
  always_comb begin
    strobe.clear   = rst;
    strobe.advance = countEn & ~rst;  // reset takes priority
  end
endmodule

// File: rtl/gray_datapath.sv
module gray_datapath
  import gray_pkg::*;
#(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_strobe_t     strobe,
  output logic [WIDTH-1:0] state
);
  localparam logic [WIDTH-1:0] TOP_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] stateQ;
  logic [WIDTH-1:0] toggle;
  logic [WIDTH-2:0] lowZero;   // lowZero[i]: all bits below i are zero
  logic             oddParity;

  initial begin
    if (WIDTH < 2) $error("gray_datapath: WIDTH must be at least 2");
  end

  assign oddParity  = ^stateQ;
  assign lowZero[0] = 1'b1;

  genvar i;
  generate
    for (i = 1; i < WIDTH - 1; i++) begin : g_low
      assign lowZero[i] = lowZero[i-1] & ~stateQ[i-1];
    end
    for (i = 0; i < WIDTH; i++) begin : g_bit
      if (i == 0) begin : g_lsb
        assign toggle[i] = ~oddParity;
      end else if (i == WIDTH - 1) begin : g_msb
        assign toggle[i] = oddParity & lowZero[i-1];
      end else begin : g_mid
        assign toggle[i] = oddParity & stateQ[i-1] & lowZero[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobe.clear)        stateQ <= '0;
    else if (strobe.advance) stateQ <= stateQ ^ toggle;
  end

  assign state = stateQ;

  AST_RESET_ZERO: assert property (@(posedge clk)
    strobe.clear |=> stateQ == '0);  // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !strobe.advance |=> $stable(stateQ));  // R3
  AST_ONE_BIT_STEP: assert property (@(posedge clk) disable iff (rst)
    strobe.advance |=> $countones(stateQ ^ $past(stateQ)) == 1);  // R4
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (strobe.advance && stateQ == TOP_ONLY) |=> stateQ == '0);  // R7
  AST_EVEN_LSB: assert property (@(posedge clk) disable iff (rst)
    (strobe.advance && !(^stateQ)) |=> (stateQ ^ $past(stateQ)) == WIDTH'(1));  // R8
  AST_ODD_UPPER: assert property (@(posedge clk) disable iff (rst)
    (strobe.advance && (^stateQ)) |=> stateQ[0] == $past(stateQ[0]));  // R8
endmodule

// File: rtl/gray_step_counter.sv
module gray_step_counter
  import gray_pkg::*;
#(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             countEn,
  output logic [WIDTH-1:0] grayOut
);
  ctrl_strobe_t strobe;

  gray_ctrl u_ctrl (
    .rst     (rst),
    .countEn (countEn),
    .strobe  (strobe)
  );

  gray_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .state  (grayOut)
  );
endmodule

// File: tb/tb_gray_step_counter.sv
module tb_gray_step_counter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic countEn = 1'b0;
  logic [2:0] q3;
  logic [1:0] q2;
  logic [4:0] q5;
  int total = 0;
  int bad = 0;
  int refCount = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  gray_step_counter #(.WIDTH(3)) dut  (.clk(clk), .rst(rst), .countEn(countEn), .grayOut(q3));
  gray_step_counter #(.WIDTH(2)) dut2 (.clk(clk), .rst(rst), .countEn(countEn), .grayOut(q2));
  gray_step_counter #(.WIDTH(5)) dut5 (.clk(clk), .rst(rst), .countEn(countEn), .grayOut(q5));

  // {enable, expected 3-bit value after the edge}
  localparam int NVEC = 12;
  localparam logic [3:0] VECS [NVEC] = '{
    4'b1_001, 4'b1_011, 4'b0_011, 4'b1_010, 4'b1_110, 4'b1_111,
    4'b1_101, 4'b1_100, 4'b0_100, 4'b1_000, 4'b1_001, 4'b1_011
  };

  function automatic logic [7:0] toGray(input int b);
    logic [7:0] v;
    v = 8'(b);
    return v ^ (v >> 1);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // one edge with the given controls; sample 1 ns after the edge
  task automatic step(input logic r, input logic e);
    @(negedge clk);
    rst = r;
    countEn = e;
    @(posedge clk);
    #1;
    if (r) refCount = 0;
    else if (e) refCount++;
  endtask

  initial begin
    logic [2:0] prev;
    logic [2:0] diff;
    step(1'b1, 1'b1);
    check("R1 reset zero", {5'b0, q3}, 8'h00);
    check("R2 reset over enable", {3'b0, q5}, 8'h00);

    for (int k = 0; k < NVEC; k++) begin
      step(1'b0, VECS[k][3]);
      if (VECS[k][3]) check("R5 table sequence", {5'b0, q3}, {5'b0, VECS[k][2:0]});
      else            check("R3 hold when idle", {5'b0, q3}, {5'b0, VECS[k][2:0]});
      if (k == 9)     check("R7 wrap to zero", {5'b0, q3}, 8'h00);
    end

    step(1'b1, 1'b0);
    check("R1 reset mid-count", {5'b0, q3}, 8'h00);
    for (int k = 0; k < 70; k++) begin
      prev = q3;
      step(1'b0, 1'b1);
      diff = q3 ^ prev;
      check("R4 one bit changes", 8'($countones(diff)), 8'd1);
      if (^prev) check("R8 odd parity spares bit0", {7'b0, diff[0]}, 8'h00);
      else       check("R8 even parity flips bit0", {5'b0, diff}, 8'h01);
      check("R6 width3 gray of count", {5'b0, q3}, toGray(refCount % 8));
      check("R6 width5 gray of count", {3'b0, q5}, toGray(refCount % 32));
      check("R9 width2 gray of count", {6'b0, q2}, toGray(refCount % 4));
    end

    step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    check("R9 width2 step1", {6'b0, q2}, 8'b01);
    step(1'b0, 1'b1);
    check("R9 width2 step2", {6'b0, q2}, 8'b11);
    step(1'b0, 1'b1);
    check("R9 width2 step3", {6'b0, q2}, 8'b10);
    step(1'b0, 1'b1);
    check("R9 width2 wrap", {6'b0, q2}, 8'b00);
    step(1'b1, 1'b1);
    check("R2 reset with enable high", {5'b0, q3}, 8'h00);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule